// File: doc/BRIEF.md
# Post-Write Command Timing Guard

This block sits beside a memory controller's command issue stage and watches every command it sends to a four-bank DDR memory. It keeps the spacing rules that follow a write burst: the write-to-read turnaround on the shared data bus, the write-recovery time before a bank may be closed, and the precharge period before a closed bank accepts anything again. The delays run from the end of the write data, not from the write command. It also models the automatic close that a write with auto precharge requests.

Each cycle the block presents allow signals for the command about to be issued. A READ or PRECHARGE issued before its delay has run out is legal but cuts the write short. The block then reports, one cycle later, which data pairs of that write must be masked. A command sent to a bank that is still precharging, or still waiting for an automatic close, is flagged as a violation one cycle later, together with its bank and opcode. A violating command changes no state. The three delays and the burst length are held in configuration registers that take new values only while the block is idle.

Top module: `postwr_guard`

## Requirements
- R1: `rd_allow` is low from the cycle after an accepted WRITE (any bank) at cycle W until cycle W+P+tWTR-1, and high from W+P+tWTR. P is the number of data pairs in a burst. An accepted READ ends this window.
- R2: An accepted READ at cycle R while `rd_allow` is low sets `trunc_valid` in cycle R+1. Bit i-1 of `trunc_mask` is set for each pair i (1..P) with i > R-W-tWTR. All other bits are zero.
- R3: For each bank, `pre_allow[b]` is high only when the bank is free and at least P+tWR cycles have passed since its last accepted WRITE. A PRECHARGE to that bank ends this window.
- R4: An accepted PRECHARGE at cycle C to a bank whose write-recovery window is still open sets `trunc_valid` in cycle C+1. Bit i-1 of `trunc_mask` is set for each pair i with i > C-W-tWR.
- R5: After an accepted PRECHARGE at cycle C, `bank_free[b]` is low for cycles C+1 to C+tRP-1 and high again at C+tRP.
- R6: An accepted WRITE with `cmd_ap` high at cycle W keeps its bank not free up to cycle A=W+P+tWR. The bank then closes and stays not free until A+tRP-1.
- R7: A command (opcode 1..4) sent to a bank that is not free raises `viol` in the next cycle, with `viol_bank` and `viol_op` holding the bank and opcode. Such a command changes no state and causes no truncation report.
- R8: `cfg_load` updates tWTR, tWR and tRP only in a cycle where no write window is open, no bank is busy and the opcode is NOP. A value of 0 is taken as 1. At all other times `cfg_load` has no effect.
- R9: `cfg_bl` sets P: code 0 gives 1 pair, code 1 gives 2 pairs, codes 2 and 3 give 4 pairs.
- R10: After reset, `rd_allow`, all `pre_allow` and all `bank_free` bits are high, `viol` and `trunc_valid` are low, and the settings are tWTR=2, tWR=3, tRP=3, P=2.
- R11: Opcodes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4. Codes 5 to 7 are treated as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Opcode of the command issued this cycle |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto precharge requested with a WRITE |
| cfg_load | input | 1 | Load new timing settings (honoured only when idle) |
| cfg_wtr | input | 4 | Write-to-read delay in cycles |
| cfg_wr | input | 4 | Write-recovery delay in cycles |
| cfg_rp | input | 4 | Precharge period in cycles |
| cfg_bl | input | 2 | Burst length code |
| rd_allow | output | 1 | A READ now does not cut a write short |
| pre_allow | output | 4 | Per bank: a PRECHARGE now is free of truncation |
| bank_free | output | 4 | Per bank: the bank accepts commands |
| viol | output | 1 | The previous command broke a timing rule |
| viol_bank | output | 2 | Bank of the violating command |
| viol_op | output | 3 | Opcode of the violating command |
| trunc_valid | output | 1 | The previous command cut a write short |
| trunc_mask | output | 4 | Pairs of the cut write that must be masked |

## Verification
An automatic close can fall in the same cycle as a truncating READ or PRECHARGE on another bank, and also in the same cycle as a command to the closing bank itself, which must then be flagged. Random streams with a high share of auto-precharge writes and short gaps produce these overlaps often. Directed writes with auto precharge followed by a command to the same bank at the close cycle hit them on purpose. Each cycle, a bench model that tracks absolute cycle numbers judges the allow vectors, the violation report and the mask together.

// File: rtl/postwr_pkg.sv
package postwr_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } op_e;

  localparam int MAXP = 4;                 // pairs in the longest burst
  localparam int PW   = $clog2(MAXP) + 1;  // width of a pair count

  // Pairs that a cut at distance 'age' from the write leaves unwritten.
  function automatic logic [MAXP-1:0] cut_mask(input int age, input int pairs, input int lim);
    logic [MAXP-1:0] m;
    m = '0;
    for (int i = 0; i < MAXP; i++)
      m[i] = ((i + 1) <= pairs) && ((i + 1 + lim) > age);
    return m;
  endfunction
endpackage

// File: rtl/postwr_cfg.sv
module postwr_cfg import postwr_pkg::*; #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          idle,
  input  logic [CW-1:0] in_wtr,
  input  logic [CW-1:0] in_wr,
  input  logic [CW-1:0] in_rp,
  input  logic [1:0]    in_bl,
  output logic [CW-1:0] t_wtr,
  output logic [CW-1:0] t_wr,
  output logic [CW-1:0] t_rp,
  output logic [PW-1:0] pairs
);
  logic [1:0] bl_q;

  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_wtr <= CW'(2);
      t_wr  <= CW'(3);
      t_rp  <= CW'(3);
      bl_q  <= 2'd1;
    end else if (load && idle) begin
      t_wtr <= at_least_one(in_wtr);
      t_wr  <= at_least_one(in_wr);
      t_rp  <= at_least_one(in_rp);
      bl_q  <= in_bl;
    end
  end

  always_comb begin
    case (bl_q)
      2'd0:    pairs = PW'(1);
      2'd1:    pairs = PW'(2);
      default: pairs = PW'(MAXP);
    endcase
  end
endmodule

// File: rtl/postwr_rdwin.sv
module postwr_rdwin import postwr_pkg::*; #(
  parameter int CW = 4,
  parameter int AW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic [PW-1:0] pairs,
  input  logic [CW-1:0] t_wtr,
  output logic          ok,
  output logic          cut,
  output logic          quiet,
  output logic [AW-1:0] age
);
  localparam logic [AW-1:0] SAT = '1;
  logic          seen;
  logic [AW-1:0] lim;

  assign lim = AW'(pairs) + AW'(t_wtr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age  <= '0;
      seen <= 1'b0;
    end else begin
      if (wr_go) begin
        age  <= AW'(1);
        seen <= 1'b1;
      end else begin
        if (age != SAT) age <= age + 1'b1;
        if (rd_go) seen <= 1'b0;
      end
    end
  end

  assign ok    = !seen || (age >= lim);
  assign cut   = seen && (age < lim);
  assign quiet = !seen;
endmodule

// File: rtl/postwr_bank.sv
module postwr_bank import postwr_pkg::*; #(
  parameter int CW = 4,
  parameter int AW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic          pre_hit,
  input  logic          ap,
  input  logic [PW-1:0] pairs,
  input  logic [CW-1:0] t_wr,
  input  logic [CW-1:0] t_rp,
  output logic          free,
  output logic          pre_ok,
  output logic          cut,
  output logic          quiet,
  output logic [AW-1:0] age
);
  localparam logic [AW-1:0] SAT = '1;
  logic          seen, ap_pend;
  logic [CW-1:0] rp_cnt;
  logic [AW-1:0] lim;

  assign lim = AW'(pairs) + AW'(t_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age     <= '0;
      seen    <= 1'b0;
      ap_pend <= 1'b0;
      rp_cnt  <= '0;
    end else begin
      if (wr_hit) begin
        age     <= AW'(1);
        seen    <= 1'b1;
        ap_pend <= ap;
      end else if (age != SAT) begin
        age <= age + 1'b1;
      end
      if (pre_hit) begin
        seen   <= 1'b0;
        rp_cnt <= t_rp - 1'b1;
      end else if (ap_pend && (age == lim)) begin
        // automatic close at end of data plus write recovery
        ap_pend <= 1'b0;
        seen    <= 1'b0;
        rp_cnt  <= t_rp - 1'b1;
      end else if (rp_cnt != '0) begin
        rp_cnt <= rp_cnt - 1'b1;
      end
    end
  end

  assign free   = !ap_pend && (rp_cnt == '0);
  assign pre_ok = free && (!seen || (age >= lim));
  assign cut    = seen && (age < lim);
  assign quiet  = free && !seen;
endmodule

// File: rtl/postwr_guard.sv
module postwr_guard import postwr_pkg::*; #(
  parameter  int NBANK = 4,
  parameter  int CW    = 4,
  localparam int BW    = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_op,
  input  logic [BW-1:0]    cmd_bank,
  input  logic             cmd_ap,
  input  logic             cfg_load,
  input  logic [CW-1:0]    cfg_wtr,
  input  logic [CW-1:0]    cfg_wr,
  input  logic [CW-1:0]    cfg_rp,
  input  logic [1:0]       cfg_bl,
  output logic             rd_allow,
  output logic [NBANK-1:0] pre_allow,
  output logic [NBANK-1:0] bank_free,
  output logic             viol,
  output logic [BW-1:0]    viol_bank,
  output logic [2:0]       viol_op,
  output logic             trunc_valid,
  output logic [MAXP-1:0]  trunc_mask
);
  localparam int AW = CW + 2;

  logic [CW-1:0]    t_wtr, t_wr, t_rp;
  logic [PW-1:0]    pairs;
  logic             is_cmd, bad, go, idle;
  logic             rd_cut, rd_quiet;
  logic [AW-1:0]    g_age;
  logic [NBANK-1:0] b_cut, b_quiet;
  logic [AW-1:0]    b_age [NBANK];
  logic             cut_any;
  logic [MAXP-1:0]  cut_m;

  assign is_cmd = (cmd_op == OP_ACT) || (cmd_op == OP_RD) ||
                  (cmd_op == OP_WR)  || (cmd_op == OP_PRE);
  assign bad    = is_cmd && !bank_free[cmd_bank];
  assign go     = is_cmd && bank_free[cmd_bank];
  assign idle   = (cmd_op == OP_NOP) && rd_quiet && (&b_quiet);

  postwr_cfg #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .idle(idle),
    .in_wtr(cfg_wtr), .in_wr(cfg_wr), .in_rp(cfg_rp), .in_bl(cfg_bl),
    .t_wtr(t_wtr), .t_wr(t_wr), .t_rp(t_rp), .pairs(pairs)
  );

  postwr_rdwin #(.CW(CW), .AW(AW)) u_rdwin (
    .clk(clk), .rst_n(rst_n),
    .wr_go(go && (cmd_op == OP_WR)), .rd_go(go && (cmd_op == OP_RD)),
    .pairs(pairs), .t_wtr(t_wtr),
    .ok(rd_allow), .cut(rd_cut), .quiet(rd_quiet), .age(g_age)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = go && (cmd_bank == BW'(b));
    postwr_bank #(.CW(CW), .AW(AW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(hit && (cmd_op == OP_WR)), .pre_hit(hit && (cmd_op == OP_PRE)),
      .ap(cmd_ap), .pairs(pairs), .t_wr(t_wr), .t_rp(t_rp),
      .free(bank_free[b]), .pre_ok(pre_allow[b]), .cut(b_cut[b]),
      .quiet(b_quiet[b]), .age(b_age[b])
    );
  end

  always_comb begin
    cut_any = 1'b0;
    cut_m   = '0;
    if (go && (cmd_op == OP_RD) && rd_cut) begin
      cut_any = 1'b1;
      cut_m   = cut_mask(int'(g_age), int'(pairs), int'(t_wtr));
    end else if (go && (cmd_op == OP_PRE) && b_cut[cmd_bank]) begin
      cut_any = 1'b1;
      cut_m   = cut_mask(int'(b_age[cmd_bank]), int'(pairs), int'(t_wr));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol        <= 1'b0;
      viol_bank   <= '0;
      viol_op     <= '0;
      trunc_valid <= 1'b0;
      trunc_mask  <= '0;
    end else begin
      viol        <= bad;
      trunc_valid <= cut_any;
      trunc_mask  <= cut_m;
      if (bad) begin
        viol_bank <= cmd_bank;
        viol_op   <= cmd_op;
      end
    end
  end
endmodule

// File: rtl/postwr_guard_chk.sv
module postwr_guard_chk #(
  parameter  int NBANK = 4,
  parameter  int MW    = 4,
  localparam int BW    = $clog2(NBANK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_op,
  input logic [BW-1:0]    cmd_bank,
  input logic             cmd_ap,
  input logic             rd_allow,
  input logic [NBANK-1:0] bank_free,
  input logic             viol,
  input logic             trunc_valid,
  input logic [MW-1:0]    trunc_mask
);
  assert_busy_cmd_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_op >= 3'd1) && (cmd_op <= 3'd4) && !bank_free[cmd_bank]) |=> viol);

  assert_no_cut_on_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> !trunc_valid);

  assert_write_closes_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_op == 3'd3) && bank_free[cmd_bank]) |=> !rd_allow);

  assert_cut_has_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_valid |-> (trunc_mask != '0));

  assert_autoclose_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_op == 3'd3) && cmd_ap && bank_free[cmd_bank]) |=> !bank_free[$past(cmd_bank)]);
endmodule

bind postwr_guard postwr_guard_chk #(.NBANK(NBANK), .MW(postwr_pkg::MAXP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
  .rd_allow(rd_allow), .bank_free(bank_free), .viol(viol),
  .trunc_valid(trunc_valid), .trunc_mask(trunc_mask)
);

// File: tb/postwr_guard_test.sv
module postwr_guard_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic       rst_n;
  logic [2:0] cmd_op;
  logic [1:0] cmd_bank;
  logic       cmd_ap, cfg_load;
  logic [3:0] cfg_wtr, cfg_wr, cfg_rp;
  logic [1:0] cfg_bl;
  logic       rd_allow, viol, trunc_valid;
  logic [3:0] pre_allow, bank_free, trunc_mask;
  logic [1:0] viol_bank;
  logic [2:0] viol_op;

  postwr_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .cfg_load(cfg_load), .cfg_wtr(cfg_wtr), .cfg_wr(cfg_wr), .cfg_rp(cfg_rp), .cfg_bl(cfg_bl),
    .rd_allow(rd_allow), .pre_allow(pre_allow), .bank_free(bank_free),
    .viol(viol), .viol_bank(viol_bank), .viol_op(viol_op),
    .trunc_valid(trunc_valid), .trunc_mask(trunc_mask)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // reference model in absolute cycle numbers
  int cyc = 0;
  int m_wtr = 2, m_wr = 3, m_rp = 3, m_p = 2;
  bit g_seen = 0;
  int g_w = 0;
  bit b_seen [4];
  int b_w [4];
  bit ap_p [4];
  int ap_at [4];
  int rp_end [4];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int fix0(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int bl_pairs(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic bit mfree(input int b);
    return !ap_p[b] && (cyc >= rp_end[b]);
  endfunction

  function automatic int mmask(input int age, input int lim);
    int m = 0;
    for (int i = 1; i <= m_p; i++)
      if (i + lim > age) m |= (1 << (i - 1));
    return m;
  endfunction

  task automatic step(input int op, input int bk, input bit ap,
                      input bit ld, input int w1, input int w2, input int w3, input int bl);
    bit ev, etv, idle, is;
    int em;
    @(negedge clk);
    cmd_op = 3'(op); cmd_bank = 2'(bk); cmd_ap = ap;
    cfg_load = ld; cfg_wtr = 4'(w1); cfg_wr = 4'(w2); cfg_rp = 4'(w3); cfg_bl = 2'(bl);
    #1;
    for (int b = 0; b < 4; b++)
      if (ap_p[b] && cyc > ap_at[b]) begin
        ap_p[b] = 0; b_seen[b] = 0; rp_end[b] = ap_at[b] + m_rp;
      end
    chk("R1/R8/R9 rd_allow", int'(rd_allow), int'(!g_seen || (cyc - g_w) >= m_p + m_wtr));
    for (int b = 0; b < 4; b++) begin
      chk("R5/R6 bank_free", int'(bank_free[b]), int'(mfree(b)));
      chk("R3 pre_allow", int'(pre_allow[b]),
          int'(mfree(b) && (!b_seen[b] || (cyc - b_w[b]) >= m_p + m_wr)));
    end
    is  = (op >= 1) && (op <= 4);   // R11: 5..7 act as NOP
    ev  = is && !mfree(bk);
    etv = 0; em = 0;
    if (is && !ev) begin
      case (op)
        2: begin
          if (g_seen && (cyc - g_w) < m_p + m_wtr) begin etv = 1; em = mmask(cyc - g_w, m_wtr); end
          g_seen = 0;
        end
        3: begin
          g_seen = 1; g_w = cyc; b_seen[bk] = 1; b_w[bk] = cyc;
          ap_p[bk] = ap; ap_at[bk] = cyc + m_p + m_wr;
        end
        4: begin
          if (b_seen[bk] && (cyc - b_w[bk]) < m_p + m_wr) begin etv = 1; em = mmask(cyc - b_w[bk], m_wr); end
          b_seen[bk] = 0; rp_end[bk] = cyc + m_rp;
        end
        default: ;
      endcase
    end
    idle = (op == 0) && !g_seen;
    for (int b = 0; b < 4; b++) if (b_seen[b] || !mfree(b)) idle = 0;
    if (ld && idle) begin
      m_wtr = fix0(w1); m_wr = fix0(w2); m_rp = fix0(w3); m_p = bl_pairs(bl);
    end
    cyc++;
    @(posedge clk); #1;
    chk("R7 viol", int'(viol), int'(ev));
    if (ev) begin
      chk("R7 viol_bank", int'(viol_bank), bk);
      chk("R7 viol_op", int'(viol_op), op);
    end
    chk("R2/R4 trunc_valid", int'(trunc_valid), int'(etv));
    if (etv) chk("R2/R4 trunc_mask", int'(trunc_mask), em);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cmd(input int op, input int bk, input bit ap);
    step(op, bk, ap, 0, 0, 0, 0, 0);
  endtask

  task automatic drain_and_load(input int w1, input int w2, input int w3, input int bl);
    nop(40);
    cmd(2, 0, 0);
    for (int b = 0; b < 4; b++) cmd(4, b, 0);
    nop(20);
    step(0, 0, 0, 1, w1, w2, w3, bl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++) begin b_seen[b] = 0; b_w[b] = 0; ap_p[b] = 0; ap_at[b] = 0; rp_end[b] = 0; end
    rst_n = 0; cmd_op = 0; cmd_bank = 0; cmd_ap = 0; cfg_load = 0;
    cfg_wtr = 0; cfg_wr = 0; cfg_rp = 0; cfg_bl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R10 reset state
    chk("R10 rd_allow", int'(rd_allow), 1);
    chk("R10 pre_allow", int'(pre_allow), 15);
    chk("R10 bank_free", int'(bank_free), 15);
    chk("R10 viol", int'(viol), 0);
    chk("R10 trunc_valid", int'(trunc_valid), 0);

    // R2: read right after write cuts every pair
    cmd(3, 0, 0); cmd(2, 1, 0);
    // R4: early precharge to the written bank
    cmd(3, 1, 0); nop(2); cmd(4, 1, 0);
    // R5: command inside tRP is flagged (R7)
    cmd(1, 1, 0); nop(2); cmd(1, 1, 0);
    // R6: auto precharge, then touch the bank at and after the close cycle
    cmd(3, 2, 1); nop(4); cmd(2, 2, 0); cmd(1, 2, 0); nop(3); cmd(1, 2, 0);
    // R8: load ignored while busy, then zeros clamp to 1 with one pair (R9)
    step(0, 0, 0, 1, 9, 9, 9, 2);
    drain_and_load(0, 0, 0, 0);
    cmd(3, 3, 0); cmd(2, 3, 0); cmd(4, 3, 0); cmd(1, 3, 0);
    // R9: long burst, R11: undefined opcodes act as NOP
    drain_and_load(3, 2, 4, 3);
    cmd(3, 0, 1); cmd(6, 0, 0); cmd(7, 1, 0); cmd(2, 1, 0); cmd(3, 1, 0);
    nop(3); cmd(4, 1, 0); nop(30);

    for (int blk = 0; blk < 12; blk++) begin
      drain_and_load(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16), int'($urandom % 4));
      for (int i = 0; i < 250; i++) begin
        r = int'($urandom % 16);
        if (r < 4)       cmd(0, 0, 0);
        else if (r < 6)  cmd(1, int'($urandom % 4), 0);
        else if (r < 9)  cmd(2, int'($urandom % 4), 0);
        else if (r < 12) cmd(3, int'($urandom % 4), ($urandom % 4) == 0);
        else if (r < 15) cmd(4, int'($urandom % 4), 0);
        else step(0, 0, 0, 1, int'($urandom % 16), int'($urandom % 16), int'($urandom % 16), int'($urandom % 4));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule